// File: doc/BRIEF.md
# Three-Axis Threshold Interrupt Generator with Orientation Modes

The block watches signed 8-bit samples on three axes and tests each one against a programmable 7-bit threshold. An axis can give a "high" event, when the value lies strictly above the threshold, or a "low" event, when it lies strictly below the negated threshold. A configuration word selects which of the six events take part. It also selects how they are combined into one interrupt line. The choices are any-of (OR), all-of (AND), movement recognition and position recognition. The last two are orientation modes, in which the device counts as being in a known zone when exactly one axis magnitude is past the threshold.

A source byte reports the active state and the six event flags. In the default mode the flags follow every sample. In latched mode they freeze at the first event until a read-clear pulse arrives. A read-clear pulse always drops the active flag and with it the interrupt line. A 4D option leaves the Z axis out of orientation detection. Work is done only on cycles where the sample strobe is high. Results appear on the registered outputs one clock after that strobe.

Top module: `thr_orient_irq`

## Requirements
- R1: For each axis, the high event is true when the signed value is greater than +thr, and the low event is true when it is less than -thr. A value exactly at either bound gives no event. Enable bits are cfg[0]=X-low, cfg[1]=X-high, cfg[2]=Y-low, cfg[3]=Y-high, cfg[4]=Z-low and cfg[5]=Z-high.
- R2: The mode field is cfg[7:6]. When cfg[7:6]=00, a sample sets the active flag if any enabled event is true.
- R3: When cfg[7:6]=10, a sample sets the active flag only if at least one event is enabled and every enabled event is true.
- R4: When cfg[7:6]=11, a sample sets the active flag for as long as the sample lies in a known zone. A known zone means exactly one considered axis is past the threshold and that axis's event in its sign is enabled. In this mode the flags hold at most that one event, and they are zero outside a known zone.
- R5: When cfg[7:6]=01, the active flag is set only by a sample in a known zone whose previous strobed sample was not in a known zone. Without latching, the flag clears at the next sample.
- R6: When cfg[9]=1 (4D), the Z axis is ignored by both orientation modes. Neither Z event can form a known zone, and neither can appear in the flags of those modes.
- R7: The source byte is {1'b0, active, ZH, ZL, YH, YL, XH, XL}, and irq equals the active flag.
- R8: With cfg[8]=0, each strobed sample rewrites the flags with the enabled events it produced. A read-clear pulse without a strobe clears the active flag and leaves the flags unchanged.
- R9: With cfg[8]=1, once the active flag is set the flags and the active flag hold through later samples until a read-clear pulse. A strobe in the same cycle as the read-clear is evaluated afresh.
- R10: After reset, the source byte and irq are zero. Without a strobe, axis and threshold changes have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | New sample strobe |
| ax | input | 8 | X axis sample, two's complement |
| ay | input | 8 | Y axis sample, two's complement |
| az | input | 8 | Z axis sample, two's complement |
| cfg | input | 10 | [5:0] event enables, [7:6] mode, [8] latch, [9] 4D |
| thr | input | 7 | Unsigned threshold |
| rd_clr | input | 1 | Read-clear pulse for the source byte |
| irq | output | 1 | Interrupt line |
| src | output | 8 | Source byte |

## Verification
Sample values are placed exactly at the threshold, one step beyond it in each sign, and at the most negative code. These cases separate strict from inclusive comparison and catch overflow in the negation. Two axes exceeding at once, as against one, tell the AND and orientation modes apart from OR. A run of known-zone samples distinguishes movement recognition, which fires once, from position recognition, which holds. A large Z value with the 4D bit set and then clear shows that Z is dropped from orientation. Read-clear pulses placed between samples, and on the same cycle as a sample, tell latched freezing from per-sample following.

// File: rtl/thr_orient_irq.sv
module thr_orient_irq #(
  parameter int DW = 8,
  parameter int TW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] ax,
  input  logic [DW-1:0] ay,
  input  logic [DW-1:0] az,
  input  logic [9:0]    cfg,
  input  logic [TW-1:0] thr,
  input  logic          rd_clr,
  output logic          irq,
  output logic [7:0]    src
);
  localparam int EW = DW + 1;

  logic [2:0][DW-1:0] av;
  logic [5:0] ev, en, zm, evm, fsel;
  logic [2:0] ex;
  logic       act, pk, known, cond, frozen;
  logic [5:0] flg;
  logic signed [EW-1:0] pt;

  assign av = {az, ay, ax};
  assign pt = EW'({1'b0, thr});

  for (genvar k = 0; k < 3; k++) begin : g_ax
    logic signed [EW-1:0] sv;
    assign sv = {av[k][DW-1], av[k]};
    assign ev[2*k]   = sv < -pt;
    assign ev[2*k+1] = sv > pt;
    assign ex[k]     = ev[2*k] | ev[2*k+1];
  end

  assign en  = cfg[5:0];
  assign zm  = {{2{~cfg[9]}}, 4'hF};
  assign evm = ev & en & zm;

  assign known = $onehot(ex & {~cfg[9], 2'b11}) && (evm != 6'd0);

  always_comb begin
    case (cfg[7:6])
      2'b00:   cond = |(ev & en);
      2'b10:   cond = (en != 6'd0) && ((ev & en) == en);
      2'b11:   cond = known;
      default: cond = known && !pk;
    endcase
  end

  assign fsel   = cfg[6] ? (known ? evm : 6'd0) : (ev & en);
  assign frozen = cfg[8] && act && !rd_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      flg <= 6'd0;
      pk  <= 1'b0;
    end else begin
      if (smp_vld) pk <= known;
      if (smp_vld && !frozen) begin
        act <= cond;
        flg <= fsel;
      end else if (rd_clr) begin
        act <= 1'b0;
      end
    end
  end

  assign irq = act;
  assign src = {1'b0, act, flg};

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[8] && act && !rd_clr) |=> (act && $stable(flg)));

  // R10
  no_strobe_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(flg));

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !smp_vld) |=> !irq);

  // R4
  orient_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && cfg[6] && !frozen) |=> $onehot0(src[5:0]));

  // R6
  fourd_noz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && cfg[6] && cfg[9] && !frozen) |=> (src[5:4] == 2'b00));
endmodule

// File: tb/thr_orient_irq_bench.sv
module thr_orient_irq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, smp_vld = 1'b0, rd_clr = 1'b0;
  logic [7:0] ax = '0, ay = '0, az = '0;
  logic [9:0] cfg = '0;
  logic [6:0] thr = '0;
  logic irq;
  logic [7:0] src;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit m_act = 0, m_pk = 0;
  bit [5:0] m_flg = 0;

  thr_orient_irq u_thr_orient_irq (.clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
    .ax(ax), .ay(ay), .az(az), .cfg(cfg), .thr(thr), .rd_clr(rd_clr),
    .irq(irq), .src(src));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD*5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (src !== e || irq !== e[6]) begin
        n_fail++;
        $display("FAIL %s: src=%h irq=%b expected src=%h irq=%b", t, src, irq, e, e[6]);
      end
    end
  end

  function automatic bit [1:0] axev(int v, int t);
    axev[1] = v > t;
    axev[0] = v < -t;
  endfunction

  task automatic step(bit vld, int x, int y, int z, bit rd, string tag);
    int xs[3];
    bit [5:0] e, fs;
    int nex;
    bit kn, cnd, frz;
    xs[0] = x; xs[1] = y; xs[2] = z;
    nex = 0;
    for (int k = 0; k < 3; k++) begin
      {e[2*k+1], e[2*k]} = axev(xs[k], int'(thr));
      if ((k < 2 || !cfg[9]) && (e[2*k+1] || e[2*k])) nex++;
    end
    fs = e & cfg[5:0];
    if (cfg[9]) fs[5:4] = 2'b00;
    kn = (nex == 1) && (fs != 0);
    case (cfg[7:6])
      2'b00: cnd = (e & cfg[5:0]) != 0;
      2'b10: cnd = (cfg[5:0] != 0) && ((e & cfg[5:0]) == cfg[5:0]);
      2'b11: cnd = kn;
      default: cnd = kn && !m_pk;
    endcase
    if (cfg[6] && !kn) fs = 0;
    if (!cfg[6]) fs = e & cfg[5:0];
    frz = cfg[8] && m_act && !rd;
    if (vld && !frz) begin m_act = cnd; m_flg = fs; end
    else if (rd) m_act = 0;
    if (vld) m_pk = kn;
    smp_vld = vld; ax = 8'(x); ay = 8'(y); az = 8'(z); rd_clr = rd;
    @(posedge clk); #1;
    exp_q.push_back({1'b0, m_act, m_flg});
    tag_q.push_back(tag);
    smp_vld = 0; rd_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD*2 + 1);
    n_chk++;
    if (src !== 8'h00 || irq !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset: src=%h expected 00", src);
    end
    rst_n = 1;
    @(posedge clk); #1;
    thr = 7'd20;
    // R1 / R2: OR mode, bounds and most negative code
    cfg = 10'b00_00_000011;
    step(1, 50, 0, 0, 0, "R2 x high");
    step(1, 20, 0, 0, 0, "R1 x at +thr");
    step(1, -20, 0, 0, 0, "R1 x at -thr");
    step(1, -21, 0, 0, 0, "R1 x low");
    step(1, -128, 0, 0, 0, "R1 most negative");
    cfg = 10'b00_00_000010;
    step(1, -60, 0, 0, 0, "R1 disabled low event");
    // R10: no strobe
    step(1, 60, 0, 0, 0, "R7 layout");
    step(0, 0, 0, 0, 0, "R10 no strobe");
    thr = 7'd100;
    step(0, 0, 0, 0, 0, "R10 thr change ignored");
    thr = 7'd20;
    // R3 AND
    cfg = 10'b00_10_001010;
    step(1, 30, 10, 0, 0, "R3 one of two");
    step(1, 30, 30, 0, 0, "R3 both");
    cfg = 10'b00_10_000000;
    step(1, 30, 30, 30, 0, "R3 none enabled");
    // R4 position
    cfg = 10'b00_11_111111;
    step(1, 50, 5, 5, 0, "R4 known x high");
    step(1, 50, 5, 5, 0, "R4 hold");
    step(1, 50, 50, 5, 0, "R4 two axes unknown");
    step(1, 0, -70, 0, 0, "R4 y low");
    // R5 movement
    cfg = 10'b00_01_111111;
    step(1, 0, 0, 0, 0, "R5 unknown");
    step(1, 0, 0, 90, 0, "R5 enter zone");
    step(1, 0, 0, 90, 0, "R5 stay in zone");
    step(1, 0, 0, 0, 0, "R5 leave");
    step(1, 0, 0, -90, 0, "R5 re-enter");
    // R6 4D
    cfg = 10'b10_11_111111;
    step(1, 0, 0, 100, 0, "R6 z ignored");
    step(1, 40, 0, 100, 0, "R6 x known despite z");
    cfg = 10'b00_11_111111;
    step(1, 0, 0, 100, 0, "R6 z used in 6D");
    // R8 non-latched
    cfg = 10'b00_00_111111;
    step(1, 0, 40, 0, 0, "R8 event");
    step(0, 0, 0, 0, 1, "R8 read clears active");
    step(1, 0, 40, 0, 0, "R8 rearm");
    step(1, 0, 0, 0, 0, "R8 flags follow");
    // R9 latched
    cfg = 10'b01_00_111111;
    step(1, 40, 0, 0, 0, "R9 latch event");
    step(1, 0, -40, 0, 0, "R9 frozen");
    step(0, 0, 0, 0, 1, "R9 read clear");
    step(1, 0, 0, 0, 0, "R9 refresh");
    step(1, 0, 0, 40, 0, "R9 latch z");
    step(1, -40, 0, 0, 1, "R9 read with strobe");
    repeat (3) @(posedge clk);
    #5;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule